// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block turns a 64-bit virtual address into a real address by walking a hierarchy of translation tables held in memory. A request carries the address, the kind of access (data read, data write or instruction fetch) and the address-space mode. The mode picks one of three space descriptors: primary, secondary or home. The type field of the chosen descriptor sets how many table levels the walk starts with, from one to four. Each region or segment level fetches one 8-byte entry. The walk then either stops at a 1 MB frame or reads a final page-table entry for a 4 KB frame.

The walker handles one translation at a time. While it is working, `busy` is high and new requests are ignored. Table entries are fetched through a valid/ready request port followed by a response strobe. The result comes back as a one-cycle `done` pulse. The pulse carries either a page-aligned real address with read/write/execute permissions, or a fault code with an exception code. A global enable bypasses translation completely. A second enable allows segment entries to map 1 MB frames directly.

Field layout used by the walker (bit numbers of the 64-bit words):
- Descriptor: table origin in bits 63:12, real-space bit 5, type in bits 3:2 (type×4 gives the starting level: 0 segment, 4 third region, 8 second region, 12 first region).
- Region entry: next-table origin in bits 63:12, invalid bit 5, type in bits 3:2.
- Segment entry: page-table origin in bits 63:11, format bit 10, protect bit 9, invalid bit 5, type in bits 3:2.
- Page entry: frame in bits 63:12, invalid bit 10, read-only bit 9.

Top module: `dat_walker`

## Requirements
- R1: With `dat_en` low, the result is the request address with bits 11:0 cleared, permissions 3'b111 (bit 2 read, bit 1 write, bit 0 execute) and fault 8'h00, and no memory fetch is made.
- R2: When the selected descriptor has its real-space bit set, the result is the page-aligned request address with no fetch and no protection check. The permissions are 3'b111, reduced as in R11.
- R3: Mode 2'd1 selects `cr_pri`, 2'd2 selects `cr_sec` and 2'd3 selects `cr_home`. Mode 2'd0 behaves as 2'd1. The space bits used in exception codes are the effective mode, which is 1 for mode 0.
- R4: Before any fetch, fault 8'h12 is returned if any address bit above bit 52 is set with start level 8, above bit 41 with start level 4, or above bit 30 with start level 0. Start level 12 has no such check.
- R5: The entry at level L is read at the current origin plus (va >> (17 + 11·L/4)) & 0x3FF8. The final page entry is read at the segment entry's bits 63:11 plus (va & 0xFF000) >> 9.
- R6: A fetched region or segment entry with its invalid bit set ends the walk with fault 8'h10.
- R7: A fetched region or segment entry whose type×4 differs from the current level ends the walk with fault 8'h12. A non-final level continues at level−4 using that entry's origin.
- R8: A segment protect bit clears write permission. When the format bit is set and `edat_en` is high, the result is entry bits 63:20 joined with va bits 19:0, and no page entry is fetched.
- R9: A page entry with its invalid bit set gives fault 8'h11. A read-only page entry clears write permission, and the frame is entry bits 63:12.
- R10: A write access whose walk ends without write permission gives fault 8'h04 with code = page-aligned va | space bits | 4. A translation fault's code is page-aligned va | space bits. Any fault reports address 0 and permissions 0.
- R11: In mode 2'd2, an instruction fetch (access 2'd2) walks through `cr_pri` and drops read and write permission. Read (2'd0) and write (2'd1) walk through `cr_sec` and drop execute permission.
- R12: Only one walk runs at a time. `busy` is high from acceptance until the `done` pulse, `done` lasts one cycle, and `req_valid` is ignored while busy.
- R13: A memory request holds `mem_req_valid` and `mem_req_addr` unchanged until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access: 0 read, 1 write, 2 instruction fetch |
| req_mode | input | 2 | Address-space mode: 1 primary, 2 secondary, 3 home |
| busy | output | 1 | Walk in progress |
| cr_pri | input | 64 | Primary space descriptor |
| cr_sec | input | 64 | Secondary space descriptor |
| cr_home | input | 64 | Home space descriptor |
| dat_en | input | 1 | Translation enable |
| edat_en | input | 1 | Allow 1 MB segment frames |
| mem_req_valid | output | 1 | Table-entry read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Fetched entry |
| done | output | 1 | One-cycle completion pulse |
| rsp_addr | output | 64 | Real address (0 on fault) |
| rsp_perm | output | 3 | Permissions {read, write, execute} |
| rsp_fault | output | 8 | 0 none, 04 protection, 10 segment, 11 page, 12 specification |
| rsp_code | output | 64 | Exception code (0 without fault) |

## Verification
The bench builds the walker with its default parameters: 64-bit addresses, 4 KB pages and 1 MB large frames. These are the only values at which the index slices and range limits have their intended meaning. The table memory is a hash of the fetch address. Each 8 KB quarter of the low address space holds entries of one level that point into the next quarter down. With this layout, walks of every depth from one to four levels complete, while occasional corrupted type fields and invalid bits reach every fault class. Short index fields keep every table inside its quarter, so the bench's own walk model sees the same memory. That model predicts the result, the fault and the exact number of fetches, so a large frame that fetched a page entry by mistake would also be caught.

// File: rtl/dat_pkg.sv
package dat_pkg;

  localparam int VA_W     = 64;
  localparam int PG_SH    = 12;
  localparam int BIG_SH   = 20;
  localparam int IDX_W    = 11;
  localparam int PIDX_W   = 8;

  // entry bit positions that the walk decodes
  localparam int B_REAL   = 5;
  localparam int B_INV    = 5;
  localparam int B_SPROT  = 9;
  localparam int B_FMT    = 10;
  localparam int B_PINV   = 10;
  localparam int B_PRO    = 9;

  localparam logic [7:0] FLT_NONE = 8'h00;
  localparam logic [7:0] FLT_PROT = 8'h04;
  localparam logic [7:0] FLT_SEG  = 8'h10;
  localparam logic [7:0] FLT_PAGE = 8'h11;
  localparam logic [7:0] FLT_SPEC = 8'h12;

  typedef enum logic [1:0] {ACC_READ, ACC_WRITE, ACC_FETCH, ACC_RSV} acc_e;
  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_REQ, ST_WAIT} st_e;

  // byte offset of the entry selected by va at a given table level
  function automatic logic [VA_W-1:0] tbl_off(input logic [VA_W-1:0] va,
                                              input logic [3:0] lvl);
    logic [IDX_W-1:0] idx;
    case (lvl[3:2])
      2'd0:    idx = va[30:20];
      2'd1:    idx = va[41:31];
      2'd2:    idx = va[52:42];
      default: idx = va[63:53];
    endcase
    return {{(VA_W-IDX_W-3){1'b0}}, idx, 3'b000};
  endfunction

  function automatic logic [VA_W-1:0] pg_off(input logic [VA_W-1:0] va);
    return {{(VA_W-PIDX_W-3){1'b0}}, va[PG_SH+PIDX_W-1:PG_SH], 3'b000};
  endfunction

endpackage

// File: rtl/dat_space_sel.sv
module dat_space_sel
  import dat_pkg::*;
#(
  parameter int AW = VA_W
) (
  input  logic [1:0]    mode,
  input  acc_e          acc,
  input  logic [AW-1:0] cr_pri,
  input  logic [AW-1:0] cr_sec,
  input  logic [AW-1:0] cr_home,
  input  logic [AW-1:0] va,
  output logic [AW-1:0] desc,
  output logic [1:0]    space,
  output logic [3:0]    start_lvl,
  output logic          real_sp,
  output logic          range_ok
);

  always_comb begin
    if (mode == 2'd0) space = 2'd1;
    else if (mode == 2'd2 && acc == ACC_FETCH) space = 2'd1;
    else space = mode;
  end

  always_comb begin
    case (space)
      2'd2:    desc = cr_sec;
      2'd3:    desc = cr_home;
      default: desc = cr_pri;
    endcase
  end

  assign start_lvl = {desc[3:2], 2'b00};
  assign real_sp   = desc[B_REAL];

  always_comb begin
    case (start_lvl[3:2])
      2'd3:    range_ok = 1'b1;
      2'd2:    range_ok = (va[AW-1:53] == '0);
      2'd1:    range_ok = (va[AW-1:42] == '0);
      default: range_ok = (va[AW-1:31] == '0);
    endcase
  end

endmodule

// File: rtl/dat_entry_chk.sv
module dat_entry_chk
  import dat_pkg::*;
#(
  parameter int AW = VA_W
) (
  input  logic [AW-1:0] entry,
  input  logic [3:0]    lvl,
  input  logic [AW-1:0] va,
  input  logic          edat,
  output logic          bad_inv,
  output logic          bad_type,
  output logic          seg_wp,
  output logic          seg_big,
  output logic [AW-1:0] big_addr,
  output logic [AW-1:0] pt_addr,
  output logic [AW-1:0] next_addr,
  output logic          pg_inv,
  output logic          pg_ro,
  output logic [AW-1:0] pg_frame
);

  localparam logic [AW-1:0] ORG_MASK = {{(AW-PG_SH){1'b1}}, {PG_SH{1'b0}}};
  localparam logic [AW-1:0] PT_MASK  = {{(AW-PG_SH+1){1'b1}}, {(PG_SH-1){1'b0}}};
  localparam logic [AW-1:0] BIG_MASK = {{(AW-BIG_SH){1'b1}}, {BIG_SH{1'b0}}};

  logic [3:0] lvl_dn;

  assign lvl_dn    = lvl - 4'd4;
  assign bad_inv   = entry[B_INV];
  assign bad_type  = ({entry[3:2], 2'b00} != lvl);
  assign seg_wp    = entry[B_SPROT];
  assign seg_big   = entry[B_FMT] & edat;
  assign big_addr  = (entry & BIG_MASK) | (va & ~BIG_MASK);
  assign pt_addr   = (entry & PT_MASK) + pg_off(va);
  assign next_addr = (entry & ORG_MASK) + tbl_off(va, lvl_dn);
  assign pg_inv    = entry[B_PINV];
  assign pg_ro     = entry[B_PRO];
  assign pg_frame  = entry & ORG_MASK;

endmodule

// File: rtl/dat_walker.sv
module dat_walker
  import dat_pkg::*;
#(
  parameter int AW = VA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_va,
  input  logic [1:0]    req_acc,
  input  logic [1:0]    req_mode,
  output logic          busy,
  input  logic [AW-1:0] cr_pri,
  input  logic [AW-1:0] cr_sec,
  input  logic [AW-1:0] cr_home,
  input  logic          dat_en,
  input  logic          edat_en,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          done,
  output logic [AW-1:0] rsp_addr,
  output logic [2:0]    rsp_perm,
  output logic [7:0]    rsp_fault,
  output logic [AW-1:0] rsp_code
);

  localparam logic [AW-1:0] PG_MASK  = {{(AW-PG_SH){1'b1}}, {PG_SH{1'b0}}};

  st_e           state;
  logic [AW-1:0] va_q;
  acc_e          acc_q;
  logic [1:0]    mode_q;
  logic          dat_q, edat_q;
  logic [3:0]    lvl_q;
  logic          page_q;
  logic          wp_q;
  logic [AW-1:0] addr_q;

  logic [AW-1:0] desc;
  logic [1:0]    space;
  logic [3:0]    start_lvl;
  logic          real_sp, range_ok;

  logic          bad_inv, bad_type, seg_wp, seg_big, pg_inv, pg_ro;
  logic [AW-1:0] big_addr, pt_addr, next_addr, pg_frame;

  dat_space_sel #(.AW(AW)) u_space (
    .mode      (mode_q),
    .acc       (acc_q),
    .cr_pri    (cr_pri),
    .cr_sec    (cr_sec),
    .cr_home   (cr_home),
    .va        (va_q),
    .desc      (desc),
    .space     (space),
    .start_lvl (start_lvl),
    .real_sp   (real_sp),
    .range_ok  (range_ok)
  );

  dat_entry_chk #(.AW(AW)) u_entry (
    .entry     (mem_rsp_data),
    .lvl       (lvl_q),
    .va        (va_q),
    .edat      (edat_q),
    .bad_inv   (bad_inv),
    .bad_type  (bad_type),
    .seg_wp    (seg_wp),
    .seg_big   (seg_big),
    .big_addr  (big_addr),
    .pt_addr   (pt_addr),
    .next_addr (next_addr),
    .pg_inv    (pg_inv),
    .pg_ro     (pg_ro),
    .pg_frame  (pg_frame)
  );

  // completion decode
  logic          fin, fin_mask, fin_walk, fin_w, prot;
  logic [7:0]    fin_fault, out_fault;
  logic [AW-1:0] fin_addr;
  logic [2:0]    perm_raw, perm_out;

  always_comb begin
    fin       = 1'b0;
    fin_mask  = 1'b0;
    fin_walk  = 1'b0;
    fin_w     = 1'b1;
    fin_fault = FLT_NONE;
    fin_addr  = '0;
    case (state)
      ST_CHECK: begin
        if (!dat_q) begin
          fin      = 1'b1;
          fin_addr = va_q;
        end else if (real_sp) begin
          fin      = 1'b1;
          fin_addr = va_q;
          fin_mask = 1'b1;
        end else if (!range_ok) begin
          fin       = 1'b1;
          fin_fault = FLT_SPEC;
        end
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (!page_q) begin
            if (bad_inv) begin
              fin       = 1'b1;
              fin_fault = FLT_SEG;
            end else if (bad_type) begin
              fin       = 1'b1;
              fin_fault = FLT_SPEC;
            end else if (lvl_q == 4'd0 && seg_big) begin
              fin      = 1'b1;
              fin_walk = 1'b1;
              fin_mask = 1'b1;
              fin_addr = big_addr;
              fin_w    = ~seg_wp;
            end
          end else begin
            fin = 1'b1;
            if (pg_inv) begin
              fin_fault = FLT_PAGE;
            end else begin
              fin_walk = 1'b1;
              fin_mask = 1'b1;
              fin_addr = pg_frame;
              fin_w    = wp_q & ~pg_ro;
            end
          end
        end
      end
      default: ;
    endcase
  end

  assign prot      = fin_walk && (acc_q == ACC_WRITE) && !fin_w;
  assign out_fault = prot ? FLT_PROT : fin_fault;
  assign perm_raw  = {1'b1, fin_w, 1'b1};

  always_comb begin
    perm_out = perm_raw;
    if (fin_mask && mode_q == 2'd2) begin
      if (acc_q == ACC_FETCH) perm_out = perm_raw & 3'b001;
      else                    perm_out = perm_raw & 3'b110;
    end
  end

  // walk sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      va_q   <= '0;
      acc_q  <= ACC_READ;
      mode_q <= 2'd0;
      dat_q  <= 1'b0;
      edat_q <= 1'b0;
      lvl_q  <= 4'd0;
      page_q <= 1'b0;
      wp_q   <= 1'b1;
      addr_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_va & PG_MASK;
            acc_q  <= acc_e'(req_acc);
            mode_q <= req_mode;
            dat_q  <= dat_en;
            edat_q <= edat_en;
            state  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (fin) begin
            state <= ST_IDLE;
          end else begin
            lvl_q  <= start_lvl;
            page_q <= 1'b0;
            wp_q   <= 1'b1;
            addr_q <= (desc & PG_MASK) + tbl_off(va_q, start_lvl);
            state  <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (fin) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_REQ;
              if (lvl_q == 4'd0) begin
                wp_q   <= ~seg_wp;
                page_q <= 1'b1;
                addr_q <= pt_addr;
              end else begin
                lvl_q  <= lvl_q - 4'd4;
                addr_q <= next_addr;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      rsp_addr  <= '0;
      rsp_perm  <= 3'b000;
      rsp_fault <= FLT_NONE;
      rsp_code  <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        rsp_fault <= out_fault;
        if (out_fault != FLT_NONE) begin
          rsp_addr <= '0;
          rsp_perm <= 3'b000;
          rsp_code <= va_q | {{(AW-3){1'b0}}, prot, space};
        end else begin
          rsp_addr <= fin_addr;
          rsp_perm <= perm_out;
          rsp_code <= '0;
        end
      end
    end
  end

  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = addr_q;

endmodule

// File: rtl/dat_walker_chk.sv
module dat_walker_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          done,
  input logic [AW-1:0] rsp_addr,
  input logic [2:0]    rsp_perm,
  input logic [7:0]    rsp_fault,
  input logic [AW-1:0] rsp_code
);

  a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r12_busy_before_done: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));

  a_r12_idle_no_fetch: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid);

  a_r13_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r10_fault_clears: assert property (@(posedge clk) disable iff (rst)
    (done && rsp_fault != 8'h00) |-> (rsp_perm == 3'b000 && rsp_addr == '0));

  a_r10_prot_code: assert property (@(posedge clk) disable iff (rst)
    (done && rsp_fault == 8'h04) |-> (rsp_code[2] && rsp_code[1:0] != 2'b00));

  a_r1_page_aligned: assert property (@(posedge clk) disable iff (rst)
    (done && rsp_fault == 8'h00) |-> (rsp_addr[11:0] == 12'h000 && rsp_code == '0));

endmodule

bind dat_walker dat_walker_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .done          (done),
  .rsp_addr      (rsp_addr),
  .rsp_perm      (rsp_perm),
  .rsp_fault     (rsp_fault),
  .rsp_code      (rsp_code)
);

// File: tb/dat_walker_tb_top.sv
module dat_walker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] SEED = 64'h5DEECE66D1234567;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [63:0] req_va;
  logic [1:0]  req_acc, req_mode;
  logic        busy;
  logic [63:0] cr_pri, cr_sec, cr_home;
  logic        dat_en, edat_en;
  logic        mem_req_valid, mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done;
  logic [63:0] rsp_addr;
  logic [2:0]  rsp_perm;
  logic [7:0]  rsp_fault;
  logic [63:0] rsp_code;

  int n_chk = 0;
  int n_err = 0;
  int fetches = 0;
  int lat = 0;
  int r13_viol = 0;
  logic [63:0] pend_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dat_walker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_acc(req_acc), .req_mode(req_mode), .busy(busy),
    .cr_pri(cr_pri), .cr_sec(cr_sec), .cr_home(cr_home),
    .dat_en(dat_en), .edat_en(edat_en),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .rsp_addr(rsp_addr),
    .rsp_perm(rsp_perm), .rsp_fault(rsp_fault), .rsp_code(rsp_code)
  );

  // table memory: every 8 KB quarter holds one level, pointing one quarter down
  function automatic logic [63:0] mem_word(input logic [63:0] a);
    logic [63:0] h, w;
    logic [1:0]  q;
    h = (a ^ SEED) * 64'h9E3779B97F4A7C15;
    h = h ^ (h >> 29);
    h = h * 64'hBF58476D1CE4E5B9;
    h = h ^ (h >> 32);
    q = a[14:13];
    w = '0;
    w[47:32] = h[47:32];
    if (q == 2'd0) w[14:11] = {2'b11, h[17:16]};
    else begin w[14:13] = q - 2'd1; w[12] = h[16]; end
    w[3:2]  = (h[7:4] == 4'd0) ? h[9:8] : q;
    w[5]    = (h[15:12] == 4'd0);
    w[10]   = (h[27:25] == 3'd0);
    w[9]    = (h[29:28] == 2'd0);
    return w;
  endfunction

  function automatic logic [63:0] offs(input logic [63:0] va, input int lvl);
    return (va >> (17 + 11 * lvl / 4)) & 64'h3FF8;
  endfunction

  // independent walk model
  task automatic ref_walk(input logic [63:0] va_in, input logic [1:0] acc,
                          input logic [1:0] mode, input logic dat, input logic edat,
                          output logic [63:0] e_addr, output logic [2:0] e_perm,
                          output logic [7:0] e_fault, output logic [63:0] e_code,
                          output int e_fetch, output string tag);
    logic [63:0] va, desc, org, e, pe;
    logic [1:0]  sp;
    logic        w, big;
    int          lvl;
    bit          stop;
    va = va_in & ~64'hFFF;
    e_fetch = 0; e_addr = '0; e_perm = 3'b000; e_fault = 8'h00; e_code = '0;
    w = 1'b1; big = 1'b0; stop = 0; tag = "R5";
    if (!dat) begin
      e_addr = va; e_perm = 3'b111; tag = "R1"; return;
    end
    sp = (mode == 2'd0) ? 2'd1 : ((mode == 2'd2 && acc == 2'd2) ? 2'd1 : mode);
    desc = (sp == 2'd1) ? cr_pri : ((sp == 2'd2) ? cr_sec : cr_home);
    if (desc[5]) begin
      e_addr = va; e_perm = 3'b111; tag = "R2";
    end else begin
      lvl = int'(desc[3:0] & 4'hC);
      if ((lvl == 8 && (va >> 53) != 0) || (lvl == 4 && (va >> 42) != 0) ||
          (lvl == 0 && (va >> 31) != 0)) begin
        e_fault = 8'h12; e_code = va | 64'(sp); tag = "R4"; return;
      end
      org = desc & ~64'hFFF;
      while (!stop) begin
        e = mem_word(org + offs(va, lvl));
        e_fetch++;
        if (e[5]) begin
          e_fault = 8'h10; e_code = va | 64'(sp); tag = "R6"; return;
        end
        if (int'({e[3:2], 2'b00}) != lvl) begin
          e_fault = 8'h12; e_code = va | 64'(sp); tag = "R7"; return;
        end
        if (lvl == 0) stop = 1;
        else begin lvl -= 4; org = e & ~64'hFFF; end
      end
      if (e[9]) w = 1'b0;
      if (e[10] && edat) begin
        e_addr = (e & ~64'hFFFFF) | (va & 64'hFFFFF); big = 1'b1; tag = "R8";
      end else begin
        pe = mem_word((e & ~64'h7FF) + ((va & 64'hFF000) >> 9));
        e_fetch++;
        if (pe[10]) begin
          e_fault = 8'h11; e_code = va | 64'(sp); tag = "R9"; return;
        end
        if (pe[9]) begin w = 1'b0; tag = "R9"; end
        e_addr = pe & ~64'hFFF;
      end
      if (acc == 2'd1 && !w) begin
        e_addr = '0; e_fault = 8'h04; e_code = va | 64'(sp) | 64'd4; tag = "R10";
        return;
      end
      e_perm = {1'b1, w, 1'b1};
    end
    if (mode == 2'd2) begin
      e_perm = (acc == 2'd2) ? (e_perm & 3'b001) : (e_perm & 3'b110);
      if (!big) tag = "R11";
    end
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder
  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(pend_addr);
        end
      end
      mem_req_ready = ($urandom % 3) != 0;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (!rst && mem_req_valid && mem_req_ready) begin
        pend_addr = mem_req_addr;
        lat = 1 + int'($urandom % 3);
        fetches++;
      end
    end
  end

  // R13 monitor: a waiting request keeps its address
  initial begin
    logic        was_wait;
    logic [63:0] was_addr;
    was_wait = 1'b0; was_addr = '0;
    forever begin
      @(negedge clk);
      if (was_wait && (!mem_req_valid || mem_req_addr !== was_addr)) r13_viol++;
      was_wait = mem_req_valid && !mem_req_ready;
      was_addr = mem_req_addr;
    end
  end

  function automatic logic [63:0] gen_va(input int t);
    logic [63:0] v;
    v = {$urandom, $urandom} & 64'hFFF;
    v[19:12] = 8'($urandom);
    v[30:20] = 11'($urandom % 8);
    if (t >= 4)  v[41:31] = 11'($urandom % 8);
    if (t >= 8)  v[52:42] = 11'($urandom % 8);
    if (t == 12) v[63:53] = 11'($urandom % 8);
    if ($urandom % 10 == 0) v[31 + ($urandom % 33)] = 1'b1;
    return v;
  endfunction

  function automatic logic [63:0] gen_desc(input int t, input bit allow_real);
    logic [63:0] d;
    d = '0;
    d[14:13] = 2'(t / 4);
    d[12]    = 1'($urandom);
    d[3:2]   = 2'(t / 4);
    if (allow_real && $urandom % 16 == 0) d[5] = 1'b1;
    return d;
  endfunction

  task automatic run_one(input logic [63:0] va, input logic [1:0] acc,
                         input logic [1:0] mode, input logic dat, input logic edat,
                         input string force_tag, input bit poke_busy);
    logic [63:0] e_addr, e_code;
    logic [2:0]  e_perm;
    logic [7:0]  e_fault;
    int          e_fetch, cyc;
    string       tag;
    ref_walk(va, acc, mode, dat, edat, e_addr, e_perm, e_fault, e_code, e_fetch, tag);
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    fetches = 0;
    req_va = va; req_acc = acc; req_mode = mode; dat_en = dat; edat_en = edat;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke_busy) begin
      req_va = ~va; req_acc = 2'd0; req_mode = 2'd3; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      check({tag, " timeout"}, 64'd0, 64'd1);
      return;
    end
    check({tag, " fault"}, 64'(rsp_fault), 64'(e_fault));
    check({tag, " addr"},  rsp_addr, e_addr);
    check({tag, " perm"},  64'(rsp_perm), 64'(e_perm));
    check({tag, " code"},  rsp_code, e_code);
    check({tag, " fetches"}, 64'(fetches), 64'(e_fetch));
    if (poke_busy) begin
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        check("R12 no second walk", {62'd0, done, busy}, 64'd0);
      end
    end
  endtask

  // search the model for an address reaching a wanted outcome
  task automatic find_and_run(input string want, input logic [1:0] acc,
                              input logic [1:0] mode, input logic edat);
    logic [63:0] e_addr, e_code, va;
    logic [2:0]  e_perm;
    logic [7:0]  e_fault;
    int          e_fetch;
    string       tag;
    for (int i = 0; i < 4000; i++) begin
      int t;
      t = 4 * int'($urandom % 4);
      cr_pri = gen_desc(t, 0); cr_sec = gen_desc(t, 0); cr_home = gen_desc(t, 0);
      va = gen_va(t);
      ref_walk(va, acc, mode, 1'b1, edat, e_addr, e_perm, e_fault, e_code, e_fetch, tag);
      if (tag == want) begin
        run_one(va, acc, mode, 1'b1, edat, "", 0);
        return;
      end
    end
    check({want, " not reachable"}, 64'd0, 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; req_valid = 1'b0; req_va = '0; req_acc = 2'd0; req_mode = 2'd1;
    dat_en = 1'b1; edat_en = 1'b0;
    cr_pri = '0; cr_sec = '0; cr_home = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 reset idle", {61'd0, busy, done, mem_req_valid}, 64'd0);

    // R1: translation disabled
    run_one(64'hDEAD_BEEF_1234_5ABC, 2'd1, 2'd2, 1'b0, 1'b0, "R1", 0);
    // R2: real-space descriptor, write through secondary drops execute
    cr_sec = 64'h20;
    run_one(64'h0000_7777_8888_9FFF, 2'd1, 2'd2, 1'b1, 1'b0, "R2", 0);
    // R3: selection by mode
    cr_pri = 64'h0; cr_sec = 64'h0; cr_home = 64'h20;
    run_one(64'hFFFF_0000_0000_0000, 2'd0, 2'd3, 1'b1, 1'b0, "R3 home", 0);
    run_one(64'hFFFF_0000_0000_0000, 2'd0, 2'd0, 1'b1, 1'b0, "R3 mode0", 0);
    cr_sec = 64'h20;
    run_one(64'hFFFF_0000_0000_0000, 2'd2, 2'd2, 1'b1, 1'b0, "R11 fetch via primary", 0);
    // R4: range limits at each starting level
    cr_pri = 64'h2000 | 64'h8;
    run_one(64'h0020_0000_0000_0000, 2'd0, 2'd1, 1'b1, 1'b0, "R4 second", 0);
    cr_pri = 64'h4;
    run_one(64'h0000_0400_0000_0000, 2'd0, 2'd1, 1'b1, 1'b0, "R4 third", 0);
    cr_pri = 64'h0;
    run_one(64'h0000_0000_8000_0000, 2'd0, 2'd1, 1'b1, 1'b0, "R4 segment", 0);
    // searched corner cases
    find_and_run("R6",  2'd0, 2'd1, 1'b0);
    find_and_run("R7",  2'd0, 2'd3, 1'b0);
    find_and_run("R8",  2'd0, 2'd1, 1'b1);
    find_and_run("R9",  2'd0, 2'd1, 1'b0);
    find_and_run("R10", 2'd1, 2'd1, 1'b0);
    find_and_run("R11", 2'd2, 2'd2, 1'b1);
    find_and_run("R5",  2'd0, 2'd3, 1'b1);
    // R12: requests while busy are ignored
    cr_pri = 64'h6000 | 64'hC;
    run_one(64'h0000_0000_0012_3000, 2'd0, 2'd1, 1'b1, 1'b0, "R12 busy", 1);

    // random mix
    for (int n = 0; n < 500; n++) begin
      int t;
      t = 4 * int'($urandom % 4);
      cr_pri  = gen_desc(t, 1);
      cr_sec  = gen_desc(4 * int'($urandom % 4), 1);
      cr_home = gen_desc(4 * int'($urandom % 4), 1);
      run_one(gen_va(t), 2'($urandom % 3), 2'($urandom % 4),
              ($urandom % 20) != 0, 1'($urandom), "", 0);
    end

    check("R13 request held", 64'(r13_viol), 64'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule